// File: doc/BRIEF.md
# Checkpointing Shared Memory with Dependency Groups

A small shared memory of `NBLK` words serves `NPORT` processor ports. Every word is held twice: a working copy that the ports read and write, and a saved copy that holds the last recovery point. Alongside the data, each word remembers which port last wrote it and whether it has been written since its last save. When a port touches a word that a different port wrote after the last save, the two ports are marked as linked in a symmetric port-by-port link matrix.

A command port starts either a save (checkpoint) or a restore (rollback) on behalf of one port. The block expands that port into the transitive closure of linked ports, then walks every word once. Each word written by a member since the last save is either saved (working copy to saved copy) or restored (saved copy to working copy). Finally the members' links and dirty marks are dropped, and a one-cycle completion pulse reports the group mask. Because the whole closure moves together, a restore never forces a further restore of anyone outside the group.

Memory access uses a request/grant handshake on each port. The lowest-numbered eligible port wins. Read data arrives one cycle after the grant. While a command runs, ports are held off where their access could disturb the group's state.

Top module: `rsm_ckpt`

## Requirements
- R1: After reset both copies of every word read as zero, no grant or read-valid is raised, and `cmd_ready` is high.
- R2: At most one port is granted per cycle, and it is the lowest-numbered port that requests and is not stalled.
- R3: A granted access returns the word's working value from before the access on that port's `rdata` slice, with `rvalid` set for that port in the cycle after the grant. A granted write replaces the working value.
- R4: An access by port i to a word that port j (j ≠ i) wrote since that word's last save or restore links i and j in both directions.
- R5: A command on `cmd_port` yields a `done` pulse whose `done_grp` bit k is set exactly for the ports in the transitive closure of links reachable from `cmd_port`. The requesting port is always included. `done_rb` is 1 for a restore and 0 for a save.
- R6: A save copies the working value into the saved copy for every word last written by a group member since its last save. Words of non-members keep their saved value.
- R7: A restore copies the saved value back into the working copy for every word last written by a group member since its last save. Words of non-members keep their working value.
- R8: On completion, all links touching group members and the dirty marks of the handled words are cleared, so an immediate new command from a member returns a group of that port alone.
- R9: While a command runs, `cmd_ready` is low and new commands are ignored. All ports are stalled during the closure and completion cycles. During the word walk, group members are stalled, and non-members are stalled only when they address a word still dirty from a member.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | NPORT | Access request, one bit per port |
| we | input | NPORT | Write enable per port |
| addr | input | NPORT*AW | Word address per port, port i at bits [i*AW +: AW] |
| wdata | input | NPORT*DW | Write data per port |
| gnt | output | NPORT | Grant, one-hot or zero, combinational |
| rvalid | output | NPORT | Read data valid, one cycle after grant |
| rdata | output | NPORT*DW | Read data per port |
| cmd_valid | input | 1 | Start a save or restore |
| cmd_rb | input | 1 | 1 = restore, 0 = save |
| cmd_port | input | PW | Port requesting the command |
| cmd_ready | output | 1 | Block idle, command accepted when high |
| done | output | 1 | Completion pulse |
| done_rb | output | 1 | Kind of the completed command |
| done_grp | output | NPORT | Group mask of the completed command |

## Verification
The bench builds a link chain across three ports and checks that a save from one end pulls in the whole chain. A design that records only direct links, or iterates the closure too few times, would return a partial mask. It then restores one port after a sibling port has written. A block that restored words by address range rather than by writer, or that failed to clear links after the save, would roll back the sibling's data or report an inflated group. It also injects a member access, a non-member access and a stray command during the word walk. An incorrect stall would let the member through, or block the unrelated port, or start a second operation. Simultaneous requests check that the lowest-numbered port wins.

// File: rtl/rsm_ckpt.sv
module rsm_ckpt #(
  parameter int NPORT = 4,
  parameter int NBLK  = 64,
  parameter int DW    = 16,
  localparam int AW   = $clog2(NBLK),
  localparam int PW   = $clog2(NPORT)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NPORT-1:0]      req,
  input  logic [NPORT-1:0]      we,
  input  logic [NPORT*AW-1:0]   addr,
  input  logic [NPORT*DW-1:0]   wdata,
  output logic [NPORT-1:0]      gnt,
  output logic [NPORT-1:0]      rvalid,
  output logic [NPORT*DW-1:0]   rdata,
  input  logic                  cmd_valid,
  input  logic                  cmd_rb,
  input  logic [PW-1:0]         cmd_port,
  output logic                  cmd_ready,
  output logic                  done,
  output logic                  done_rb,
  output logic [NPORT-1:0]      done_grp
);
  localparam int CW = $clog2((NBLK > NPORT) ? NBLK : NPORT) + 1;

  typedef enum logic [1:0] {S_IDLE, S_CLOSE, S_COPY, S_DONE} st_t;

  logic [DW-1:0]    cur [NBLK];
  logic [DW-1:0]    rec [NBLK];
  logic [PW-1:0]    own [NBLK];
  logic [NBLK-1:0]  mod;
  logic [NPORT-1:0] dep [NPORT];

  st_t              st;
  logic [NPORT-1:0] grp, grp_nxt;
  logic             rb;
  logic [CW-1:0]    cnt;

  logic             closing, copying, finishing;
  logic [NPORT-1:0] stall, elig;
  logic [PW-1:0]    win;
  logic             any;
  logic [AW-1:0]    w_a, blk;
  logic             w_we, hit;
  logic [DW-1:0]    w_d;

  assign closing   = (st == S_CLOSE);
  assign copying   = (st == S_COPY);
  assign finishing = (st == S_DONE);
  assign cmd_ready = (st == S_IDLE);
  assign done      = finishing;
  assign done_rb   = rb;
  assign done_grp  = grp;

  always_comb begin
    for (int i = 0; i < NPORT; i++)
      stall[i] = closing | finishing |
                 (copying & (grp[i] | (mod[addr[i*AW +: AW]] & grp[own[addr[i*AW +: AW]]])));
  end

  assign elig = req & ~stall;
  assign gnt  = elig & (~elig + 1'b1);
  assign any  = |elig;

  always_comb begin
    win = '0;
    for (int i = NPORT-1; i >= 0; i--)
      if (elig[i]) win = PW'(i);
  end

  assign w_a  = addr[win*AW +: AW];
  assign w_d  = wdata[win*DW +: DW];
  assign w_we = we[win];

  always_comb begin
    grp_nxt = grp;
    for (int k = 0; k < NPORT; k++)
      if (grp[k]) grp_nxt = grp_nxt | dep[k];
  end

  assign blk = cnt[AW-1:0];
  assign hit = copying & mod[blk] & grp[own[blk]];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      grp <= '0;
      rb  <= 1'b0;
      cnt <= '0;
    end else begin
      case (st)
        S_IDLE: if (cmd_valid) begin
          grp <= NPORT'(1) << cmd_port;
          rb  <= cmd_rb;
          cnt <= '0;
          st  <= S_CLOSE;
        end
        S_CLOSE: begin
          grp <= grp_nxt;
          if (cnt == CW'(NPORT-2)) begin
            cnt <= '0;
            st  <= S_COPY;
          end else cnt <= cnt + 1'b1;
        end
        S_COPY: begin
          if (cnt == CW'(NBLK-1)) st <= S_DONE;
          else cnt <= cnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < NBLK; b++) begin
        cur[b] <= '0;
        rec[b] <= '0;
        own[b] <= '0;
      end
      mod <= '0;
      for (int k = 0; k < NPORT; k++) dep[k] <= '0;
      rdata  <= '0;
      rvalid <= '0;
    end else begin
      rvalid <= gnt;
      if (hit) begin
        if (rb) cur[blk] <= rec[blk];
        else    rec[blk] <= cur[blk];
        mod[blk] <= 1'b0;
      end
      if (any) begin
        rdata[win*DW +: DW] <= cur[w_a];
        if (mod[w_a] && own[w_a] != win) begin
          dep[win][own[w_a]] <= 1'b1;
          dep[own[w_a]][win] <= 1'b1;
        end
        if (w_we) begin
          cur[w_a] <= w_d;
          own[w_a] <= win;
          mod[w_a] <= 1'b1;
        end
      end
      if (finishing) begin
        for (int k = 0; k < NPORT; k++)
          dep[k] <= grp[k] ? '0 : (dep[k] & ~grp);
      end
    end
  end
endmodule

// File: rtl/rsm_ckpt_chk.sv
module rsm_ckpt_chk #(
  parameter int NPORT = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPORT-1:0] req,
  input logic [NPORT-1:0] gnt,
  input logic [NPORT-1:0] rvalid,
  input logic [NPORT-1:0] stall,
  input logic [NPORT-1:0] grp,
  input logic             copying,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic             done,
  input logic [NPORT-1:0] done_grp
);
  a_r2_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  a_r2_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (((gnt - 1'b1) & req & ~stall) == '0) && ((gnt & ~(req & ~stall)) == '0));

  a_r3_rvalid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> rvalid == $past(gnt));

  a_r9_member_held: assert property (@(posedge clk) disable iff (!rst_n)
    copying |-> (gnt & grp) == '0);

  a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

  a_r5_group_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> done_grp != '0);
endmodule

bind rsm_ckpt rsm_ckpt_chk #(.NPORT(NPORT)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .gnt(gnt), .rvalid(rvalid),
  .stall(stall), .grp(grp), .copying(copying), .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready), .done(done), .done_grp(done_grp)
);

// File: tb/rsm_ckpt_test.sv
module rsm_ckpt_test;
  localparam int P = 4, N = 64, DW = 16, AW = 6, PW = 2;

  logic clk = 0, rst_n = 0;
  logic [P-1:0] req = '0, we = '0;
  logic [P*AW-1:0] addr = '0;
  logic [P*DW-1:0] wdata = '0;
  logic [P-1:0] gnt, rvalid, done_grp;
  logic [P*DW-1:0] rdata;
  logic cmd_valid = 0, cmd_rb = 0, cmd_ready, done, done_rb;
  logic [PW-1:0] cmd_port = '0;

  rsm_ckpt #(.NPORT(P), .NBLK(N), .DW(DW)) uut (.*);

  always #2 clk = ~clk;

  int tests = 0, fails = 0, cyc = 0, ndone = 0;
  logic [DW-1:0] m_cur [N];
  logic [DW-1:0] m_rec [N];
  int            m_own [N];
  logic [N-1:0]  m_mod;
  logic [P-1:0]  m_dep [P];

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  always @(negedge clk) if (rst_n && done) ndone++;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [P-1:0] closure(input int s);
    logic [P-1:0] g = P'(1) << s;
    for (int it = 0; it < P; it++)
      for (int k = 0; k < P; k++)
        if (g[k]) g = g | m_dep[k];
    return g;
  endfunction

  task automatic model_access(input int p, input bit w, input int a, input logic [DW-1:0] d);
    if (m_mod[a] && m_own[a] != p) begin
      m_dep[p][m_own[a]] = 1'b1;
      m_dep[m_own[a]][p] = 1'b1;
    end
    if (w) begin
      m_cur[a] = d; m_own[a] = p; m_mod[a] = 1'b1;
    end
  endtask

  task automatic model_cmd(input logic [P-1:0] g, input bit r);
    for (int b = 0; b < N; b++)
      if (m_mod[b] && g[m_own[b]]) begin
        if (r) m_cur[b] = m_rec[b]; else m_rec[b] = m_cur[b];
        m_mod[b] = 1'b0;
      end
    for (int k = 0; k < P; k++)
      m_dep[k] = g[k] ? '0 : (m_dep[k] & ~g);
  endtask

  task automatic access(input int p, input bit w, input int a, input logic [DW-1:0] d, input string tag);
    logic [DW-1:0] exp;
    @(negedge clk);
    req[p] = 1'b1; we[p] = w;
    addr[p*AW +: AW] = AW'(a); wdata[p*DW +: DW] = d;
    #1;
    while (!gnt[p]) begin @(negedge clk); #1; end
    exp = m_cur[a];
    @(posedge clk); #1;
    chk(rvalid[p] && rdata[p*DW +: DW] == exp, tag, rdata[p*DW +: DW], exp);
    req[p] = 1'b0; we[p] = 1'b0;
    model_access(p, w, a, d);
  endtask

  task automatic command(input int p, input bit r, input string tag);
    logic [P-1:0] g = closure(p);
    @(negedge clk); #1;
    while (!cmd_ready) begin @(negedge clk); #1; end
    cmd_valid = 1; cmd_rb = r; cmd_port = PW'(p);
    @(posedge clk); #1;
    cmd_valid = 0;
    while (!done) begin @(negedge clk); #1; end
    chk(done_grp == g && done_rb == r, tag, done_grp, g);
    model_cmd(g, r);
  endtask

  initial begin
    int seed;
    logic [P-1:0] g;
    int nd;
    seed = $urandom(32'd2024);
    for (int b = 0; b < N; b++) begin
      m_cur[b] = '0; m_rec[b] = '0; m_own[b] = 0;
    end
    m_mod = '0;
    for (int k = 0; k < P; k++) m_dep[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    chk(cmd_ready && gnt == '0 && rvalid == '0, "R1 reset outputs", {cmd_ready, gnt, rvalid}, 9'h100);

    req = 4'b1110; #1;
    chk(gnt == 4'b0010, "R2 lowest port wins", gnt, 4'b0010);
    @(posedge clk); #1;
    req = '0;
    chk(rvalid == 4'b0010 && rdata[DW +: DW] == 0, "R1 R3 reset word read", rdata[DW +: DW], 0);

    access(0, 1, 5, 16'hA5A5, "R3 write");
    access(0, 0, 5, 0, "R3 read back");

    access(0, 1, 10, 16'h1111, "R3 write p0");
    access(1, 0, 10, 0, "R4 read links p1 p0");
    access(1, 1, 11, 16'h2222, "R3 write p1");
    access(2, 0, 11, 0, "R4 read links p2 p1");
    access(3, 1, 20, 16'h3333, "R3 write p3");
    command(0, 0, "R5 chain group 0111");
    chk(done_grp == 4'b0111, "R5 R4 transitive mask", done_grp, 4'b0111);
    command(3, 0, "R5 lone group 1000");

    access(0, 1, 10, 16'h4444, "R3 overwrite p0");
    access(3, 1, 20, 16'h5555, "R3 overwrite p3");
    command(0, 1, "R8 rollback group only p0");
    chk(done_grp == 4'b0001, "R8 links cleared", done_grp, 4'b0001);
    access(0, 0, 10, 0, "R7 restored value");
    access(3, 0, 20, 0, "R7 non-member kept");
    access(1, 0, 11, 0, "R6 saved word read");
    command(3, 1, "R6 rollback p3");
    access(3, 0, 20, 0, "R6 non-member save kept");

    access(0, 1, 12, 16'h6666, "R3 write p0 12");
    g = closure(0);
    nd = ndone;
    @(negedge clk); #1;
    cmd_valid = 1; cmd_rb = 0; cmd_port = 0;
    @(posedge clk); #1;
    cmd_valid = 0;
    chk(!cmd_ready, "R9 busy after accept", cmd_ready, 0);
    repeat (4) @(negedge clk);
    req[0] = 1; we[0] = 0; addr[0 +: AW] = 12;
    req[3] = 1; we[3] = 1; addr[3*AW +: AW] = 40; wdata[3*DW +: DW] = 16'h7777;
    cmd_valid = 1; cmd_port = 3;
    #1;
    chk(gnt == 4'b1000, "R9 member held non-member served", gnt, 4'b1000);
    @(posedge clk); #1;
    req[3] = 0; we[3] = 0; cmd_valid = 0;
    model_access(3, 1, 40, 16'h7777);
    forever begin
      @(negedge clk); #1;
      if (done) begin
        chk(done_grp == g, "R5 stalled op group", done_grp, g);
        model_cmd(g, 0);
      end
      if (gnt[0]) break;
    end
    @(posedge clk); #1;
    req[0] = 0;
    chk(rdata[0 +: DW] == m_cur[12], "R9 member read after op", rdata[0 +: DW], m_cur[12]);
    repeat (80) @(negedge clk);
    #1;
    chk(ndone == nd + 1 && cmd_ready, "R9 stray command ignored", ndone, nd + 1);

    for (int i = 0; i < 400; i++) begin
      int p = int'($urandom % P);
      if ($urandom % 16 == 0)
        command(p, bit'($urandom % 2), "R5 R6 R7 random command");
      else
        access(p, bit'($urandom % 2), int'($urandom % 8), DW'($urandom), "R3 R4 random access");
    end
    for (int b = 0; b < 8; b++) access(b % P, 0, b, 0, "R3 final sweep");
    summary();
  end
endmodule